// File: doc/BRIEF.md
# Chip Sequence Playback Trigger Controller

This block drives the read address of a waveform memory that holds a precomputed chip sequence. It steps the address once per chip strobe and wraps it at a configured sequence length. It decides when playback begins and when it restarts according to one of four trigger modes. In the free-running mode the sequence loops from reset and ignores all triggers. In the three triggered modes, playback is started or restarted by an edge on an external trigger line or by a manual trigger pulse. The controller can also hold its output idle until the first trigger arrives.

Each accepted trigger fires a one-cycle trigger-out pulse. The start then waits a programmable number of chips, and a programmable number of chips must pass before another trigger is accepted. The external line passes through a synchronizer, and either of its edges can be selected as the active one. The controller reads the configuration inputs only while it is idle, meaning not playing and with no start pending. While it plays, it keeps the values it captured last.

Top module: `chipseq_trig_ctrl`

## Requirements
- R1: In the armed modes (cfg_mode 2 and 3), from reset until a start, rd_valid is 0 and rd_addr is 0.
- R2: In mode 0 (free run), playback begins with rd_addr 0 and rd_valid 1 at the first clock edge after reset is released. Triggers never produce trig_out.
- R3: rd_addr advances by one on each clock edge where chip_en is 1 and holds otherwise. It returns to 0 after reaching cfg_seq_len-1. A length of 0 selects the full 2^ADDR_W address range.
- R4: trig_ext passes through two flops before edge detection. cfg_edge_fall=0 selects rising edges and 1 selects falling edges. After trig_ext changes, the trigger appears in the cycle following the second rising clock edge.
- R5: A trigger on trig_manual is accepted in the same cycle it is high, and trig_out is asserted combinationally in that cycle.
- R6: With cfg_delay 0, rd_addr is 0 and rd_valid is 1 at the clock edge that ends the accepting cycle. With cfg_delay D>0, the restart happens at the edge carrying the D-th chip_en after that cycle.
- R7: For cfg_inhibit chip_en strobes after an accepted trigger, further triggers give no trig_out and do not restart playback.
- R8: A trigger that arrives while a start delay is counting is ignored.
- R9: In mode 1 (retrigger), playback runs from reset. Each accepted trigger restarts it from address 0, and playback continues while the delay counts.
- R10: In mode 2 (armed once), the first accepted trigger starts playback. Later triggers give no trig_out and leave the address unchanged.
- R11: In mode 3 (armed retrigger), every accepted trigger after the first restarts playback from address 0.
- R12: Changes to cfg_seq_len while playback runs have no effect until the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | One-cycle chip strobe that advances all counters |
| cfg_mode | input | 2 | 0 free run, 1 retrigger, 2 armed once, 3 armed retrigger |
| cfg_edge_fall | input | 1 | 1 selects the falling edge of trig_ext as active |
| cfg_seq_len | input | ADDR_W | Sequence length in chips, 0 means 2^ADDR_W |
| cfg_delay | input | DLY_W | Start delay in chips |
| cfg_inhibit | input | INH_W | Retrigger lockout in chips |
| trig_ext | input | 1 | Asynchronous external trigger line |
| trig_manual | input | 1 | Synchronous manual trigger pulse |
| rd_addr | output | ADDR_W | Waveform memory read address |
| rd_valid | output | 1 | High while playback is running |
| trig_out | output | 1 | Pulse for each accepted trigger |

## Verification
Three events can fall on the same clock edge. A restart at the end of a start delay can coincide with a chip strobe that would otherwise advance the address. The bench provokes this in retrigger mode with chip_en held high through the delay's final count, and expects address 0 rather than the advanced value. The bench also presents triggers while the inhibit window is still one chip from closing and in the cycle just after it closes. It judges acceptance by trig_out and by whether the address jumps back to 0.

// File: rtl/cstc_pkg.sv
package cstc_pkg;
  typedef enum logic [1:0] {
    MODE_FREE       = 2'd0,
    MODE_RETRIG     = 2'd1,
    MODE_ARM_ONCE   = 2'd2,
    MODE_ARM_RETRIG = 2'd3
  } play_mode_e;

  function automatic logic mode_is_armed(input play_mode_e m);
    return (m == MODE_ARM_ONCE) || (m == MODE_ARM_RETRIG);
  endfunction

  function automatic logic mode_takes_trig(input play_mode_e m);
    return m != MODE_FREE;
  endfunction
endpackage

// File: rtl/cstc_trig_sync.sv
module cstc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic fall_sel,
  output logic edge_pulse
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic             sync_now;
  logic             sync_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN-2:0], async_in};
  end

  assign sync_now  = chain_q[STAGES-1];
  assign sync_prev = chain_q[STAGES];

  function automatic logic pick_edge(input logic cur, input logic prv, input logic fall);
    return fall ? (prv & ~cur) : (cur & ~prv);
  endfunction

  assign edge_pulse = pick_edge(sync_now, sync_prev, fall_sel);

  // R4
  edge_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pulse && $stable(fall_sel)) |=> !edge_pulse);
endmodule

// File: rtl/cstc_down_cnt.sv
module cstc_down_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         busy,
  output logic         expire
);
  function automatic logic [W-1:0] dec_sat(input logic [W-1:0] v, input logic t);
    return (t && v != '0) ? v - 1'b1 : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else           cnt <= dec_sat(cnt, tick);
  end

  assign busy   = cnt != '0;
  assign expire = tick && !load && (cnt == {{(W-1){1'b0}}, 1'b1});

  // R7
  no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> (cnt <= $past(cnt)));
endmodule

// File: rtl/cstc_addr_gen.sv
module cstc_addr_gen #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] addr,
  output logic          run
);
  function automatic logic [AW-1:0] wrap_next(input logic [AW-1:0] a, input logic [AW-1:0] l);
    logic [AW-1:0] last;
    last = l - 1'b1;
    return (a == last) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      run  <= 1'b0;
    end else if (start) begin
      addr <= '0;
      run  <= 1'b1;
    end else if (run && tick) begin
      addr <= wrap_next(addr, len);
    end
  end

  // R1
  idle_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (addr == '0));

  // R3
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len != '0) |-> (addr < len));

  // R9
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> run);
endmodule

// File: rtl/chipseq_trig_ctrl.sv
module chipseq_trig_ctrl
  import cstc_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DLY_W       = 16,
  parameter int INH_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_edge_fall,
  input  logic [ADDR_W-1:0] cfg_seq_len,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [INH_W-1:0]  cfg_inhibit,
  input  logic              trig_ext,
  input  logic              trig_manual,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic              trig_out
);
  play_mode_e        mode_live, mode_sh, mode_eff;
  logic [ADDR_W-1:0] len_sh, len_eff;
  logic [DLY_W-1:0]  dly_sh, dly_eff, dly_cnt;
  logic [INH_W-1:0]  inh_sh, inh_eff, inh_cnt;
  logic              run, idle;
  logic              ext_edge, trig_evt, trig_blocked, trig_accept;
  logic              dly_busy, dly_expire, dly_load;
  logic              inh_busy, inh_expire_unused;
  logic              free_start, start;

  assign mode_live = play_mode_e'(cfg_mode);
  assign idle      = !run && !dly_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_sh <= MODE_FREE;
      len_sh  <= '0;
      dly_sh  <= '0;
      inh_sh  <= '0;
    end else if (idle) begin
      mode_sh <= mode_live;
      len_sh  <= cfg_seq_len;
      dly_sh  <= cfg_delay;
      inh_sh  <= cfg_inhibit;
    end
  end

  assign mode_eff = idle ? mode_live   : mode_sh;
  assign len_eff  = idle ? cfg_seq_len : len_sh;
  assign dly_eff  = idle ? cfg_delay   : dly_sh;
  assign inh_eff  = idle ? cfg_inhibit : inh_sh;

  cstc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(trig_ext),
    .fall_sel(cfg_edge_fall), .edge_pulse(ext_edge)
  );

  assign trig_evt     = ext_edge || trig_manual;
  assign trig_blocked = !mode_takes_trig(mode_eff) || dly_busy || inh_busy ||
                        ((mode_eff == MODE_ARM_ONCE) && run);
  assign trig_accept  = trig_evt && !trig_blocked;
  assign dly_load     = trig_accept && (dly_eff != '0);

  cstc_down_cnt #(.W(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_eff),
    .tick(chip_en), .cnt(dly_cnt), .busy(dly_busy), .expire(dly_expire)
  );

  cstc_down_cnt #(.W(INH_W)) u_inhibit (
    .clk(clk), .rst_n(rst_n), .load(trig_accept), .load_val(inh_eff),
    .tick(chip_en), .cnt(inh_cnt), .busy(inh_busy), .expire(inh_expire_unused)
  );

  assign free_start = idle && !mode_is_armed(mode_eff);
  assign start      = free_start || (trig_accept && (dly_eff == '0)) || dly_expire;

  cstc_addr_gen #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(chip_en),
    .len(len_eff), .addr(rd_addr), .run(run)
  );

  assign rd_valid = run;
  assign trig_out = trig_accept;

  // R6
  accept_leads_somewhere_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> (rd_valid || dly_busy));

  // R7
  inhibit_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> (inh_cnt == $past(inh_eff)));

  // R8
  no_trig_in_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_cnt > 1) |=> !$rose(trig_out) || !dly_busy || (dly_cnt < $past(dly_cnt)) || !trig_out);

  // R2
  free_mode_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_sh == MODE_FREE) |-> !trig_out);
endmodule

// File: tb/tb_chipseq_trig_ctrl.sv
module tb_chipseq_trig_ctrl;
  localparam int AW = 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          chip_en = 0;
  logic [1:0]    cfg_mode = 0;
  logic          cfg_edge_fall = 0;
  logic [AW-1:0] cfg_seq_len = 5;
  logic [15:0]   cfg_delay = 0;
  logic [15:0]   cfg_inhibit = 0;
  logic          trig_ext = 0;
  logic          trig_manual = 0;
  logic [AW-1:0] rd_addr;
  logic          rd_valid;
  logic          trig_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chipseq_trig_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cfg_mode(cfg_mode),
    .cfg_edge_fall(cfg_edge_fall), .cfg_seq_len(cfg_seq_len), .cfg_delay(cfg_delay),
    .cfg_inhibit(cfg_inhibit), .trig_ext(trig_ext), .trig_manual(trig_manual),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .trig_out(trig_out)
  );

  // [5]=chip_en [4]=manual [3:0]=expected address after the edge (free run, length 5)
  localparam logic [5:0] VEC [8] = '{
    6'b1_0_0001, 6'b1_1_0010, 6'b0_0_0010, 6'b1_0_0011,
    6'b1_1_0100, 6'b1_0_0000, 6'b0_1_0000, 6'b1_0_0001
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 0; chip_en = 0; trig_manual = 0; cfg_mode = m;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic pulse_en(input int n);
    chip_en = 1;
    for (int i = 0; i < n; i++) step();
    chip_en = 0;
  endtask

  initial begin
    @(negedge clk);
    // free run table walk
    cfg_seq_len = 5;
    do_reset(2'd0);
    chk("R2 start valid", rd_valid, 1);
    chk("R2 start addr", rd_addr, 0);
    for (int i = 0; i < 8; i++) begin
      chip_en = VEC[i][5];
      trig_manual = VEC[i][4];
      #1;
      chk("R2 no trig_out", trig_out, 0);
      step();
      chk("R3 table addr", rd_addr, int'(VEC[i][3:0]));
    end
    chip_en = 0; trig_manual = 0;

    // R12: length change while running has no effect
    do_reset(2'd0);
    cfg_seq_len = 3;
    pulse_en(4);
    chk("R12 held length", rd_addr, 4);
    pulse_en(1);
    chk("R12 wrap at old length", rd_addr, 0);

    // R3 length 0 = full range
    cfg_seq_len = 0;
    do_reset(2'd0);
    pulse_en(15);
    chk("R3 full range top", rd_addr, 15);
    pulse_en(1);
    chk("R3 full range wrap", rd_addr, 0);

    // armed once, rising edge, delay 0
    cfg_seq_len = 4; cfg_delay = 0; cfg_inhibit = 0; cfg_edge_fall = 0;
    do_reset(2'd2);
    pulse_en(3);
    chk("R1 idle valid", rd_valid, 0);
    chk("R1 idle addr", rd_addr, 0);
    trig_ext = 1;
    step();
    chk("R4 not yet through sync", trig_out, 0);
    step();
    chk("R4 rising edge accepted", trig_out, 1);
    step();
    chk("R6 zero delay start valid", rd_valid, 1);
    chk("R6 zero delay start addr", rd_addr, 0);
    chk("R4 single pulse", trig_out, 0);
    pulse_en(5);
    chk("R3 wrap at 4", rd_addr, 1);
    trig_manual = 1; #1;
    chk("R10 later trig ignored", trig_out, 0);
    step(); trig_manual = 0;
    chk("R10 addr unchanged", rd_addr, 1);
    trig_ext = 0;

    // armed retrigger, falling edge, delay 3
    cfg_edge_fall = 1; cfg_delay = 3; cfg_seq_len = 8;
    trig_ext = 1;
    do_reset(2'd3);
    step(); step(); step(); step();
    chk("R4 rise ignored when fall selected", rd_valid, 0);
    trig_ext = 0;
    step();
    chk("R4 falling not yet", trig_out, 0);
    step();
    chk("R4 falling edge accepted", trig_out, 1);
    step();
    chk("R6 delay pending idle", rd_valid, 0);
    trig_manual = 1; #1;
    chk("R8 trig in delay ignored", trig_out, 0);
    step(); trig_manual = 0;
    pulse_en(2);
    chk("R6 before delay end", rd_valid, 0);
    pulse_en(1);
    chk("R6 delayed start valid", rd_valid, 1);
    chk("R6 delayed start addr", rd_addr, 0);

    // armed retrigger, inhibit 3, manual triggers
    cfg_edge_fall = 0; cfg_delay = 0; cfg_inhibit = 3;
    do_reset(2'd3);
    trig_manual = 1; #1;
    chk("R5 manual same cycle", trig_out, 1);
    step(); trig_manual = 0;
    chk("R5 start addr", rd_addr, 0);
    pulse_en(2);
    trig_manual = 1; #1;
    chk("R7 inhibited trig", trig_out, 0);
    step(); trig_manual = 0;
    chk("R7 no restart", rd_addr, 2);
    pulse_en(1);
    chk("R7 addr after window", rd_addr, 3);
    trig_manual = 1; #1;
    chk("R11 retrigger accepted", trig_out, 1);
    step(); trig_manual = 0;
    chk("R11 restart addr", rd_addr, 0);

    // retrigger mode, delay 2, restart collides with chip strobe
    cfg_seq_len = 6; cfg_delay = 2; cfg_inhibit = 0;
    do_reset(2'd1);
    chk("R9 runs from reset", rd_valid, 1);
    pulse_en(3);
    trig_manual = 1; #1;
    chk("R9 trig accepted", trig_out, 1);
    step(); trig_manual = 0;
    chk("R9 plays during delay", rd_addr, 3);
    pulse_en(1);
    chk("R9 still advancing", rd_addr, 4);
    pulse_en(1);
    chk("R6 restart wins over advance", rd_addr, 0);
    chk("R9 valid after restart", rd_valid, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule